// File: doc/BRIEF.md
# Quadrature Encoder Position Counter with Configuration Lock

This block turns the two phase signals of an incremental rotary or linear encoder into a 16-bit position count. Both phase inputs pass through synchronisers. Every edge of either phase is decoded into one step, up or down, so one full encoder cycle gives four steps. An optional power-of-two divider thins the decoded steps before they reach the counter. The counter runs between a programmable start value and a limit value. When it passes either end, it wraps to the other end and sets a sticky wrap flag.

Software reaches the block over a small word-addressed register bus. Writes take effect on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`. A lock bit guards the configuration. Once set, the lock can only be cleared through a separate unlock bit in the control register. Writing any data to the position register does not store that data. It reloads the count from the start register instead.

Register map (word addresses):

| Addr | Name | Fields |
|------|------|--------|
| 0 | CTRL | bit0 run enable; bit1 unlock, write-only action, reads 0 |
| 1 | GUARD | bit0 lock |
| 2 | DIVSTAT | bits2:0 divider select; bit7 wrap flag |
| 3 | POS | current count (read); a write reloads the count |
| 4 | LIMIT | upper end of the count range |
| 5 | START | lower end of the count range and reload value |
| 6 | QCTRL | bit0 quadrature enable |
| 7 | — | reads zero |

Top module: `qdec_timer`

## Requirements
- R1: After reset the registers read as follows: CTRL=0, GUARD=0, DIVSTAT=0, POS=0, LIMIT=0xFFFF, START=0, QCTRL=0.
- R2: The phase state {A,B} advances through the order 00, 10, 11, 01, 00. A move one position forward in this order is a step up, and a move one position back is a step down. The position output changes on the third rising clock edge after the phase input changes.
- R3: When both phases change in the same sample, or neither phase changes, the count stays the same.
- R4: A step up applied at count==LIMIT loads START. A step down applied at count==START loads LIMIT. Either wrap sets DIVSTAT bit7, which stays set until software writes 1 to DIVSTAT bit7. If a wrap and a clear happen in the same cycle, the flag is set.
- R5: With divider select n in DIVSTAT bits2:0, only every 2^n-th decoded step reaches the counter. The divider counts steps in either direction.
- R6: A write of any data to POS loads the count from START and clears the divider's internal count. A step in the same cycle is discarded.
- R7: While CTRL bit0 is 0, writes to START and QCTRL are ignored.
- R8: Writing 1 to GUARD bit0 sets the lock. While locked, writes to CTRL bit0, DIVSTAT bits2:0, LIMIT, START and QCTRL are ignored. POS reloads, wrap-flag clears and all reads still work.
- R9: Writing 1 to CTRL bit1 clears the lock. Writing 0 to GUARD bit0 does not clear the lock.
- R10: Counting stops only when CTRL bit0 and QCTRL bit0 are both 0.
- R11: Address 7 reads as zero, and unused bits of every register read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| pos_o | output | 16 | Current count |

## Verification
The embedded assertions check on every cycle the rules that hold in any sequence of inputs:
- a reload takes the start value;
- a step applied inside the range moves the count by exactly one;
- wraps land on the opposite end of the range;
- the count stays still when no step is applied;
- the lock persists until it is released through the unlock bit;
- a locked or disabled register does not change;
- a wrap always leaves the flag set.

Other behaviour depends on the history of the phase inputs, so only the bench scenarios can show it. This covers the x4 direction decode and its three-cycle latency, the discarding of double-phase jumps, divider thinning, and the fact that a reload empties the divider. The bench's cycle model also confirms that these interact correctly with the lock and the enable gate.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_GUARD  = 3'd1,
        RA_DIVST  = 3'd2,
        RA_POS    = 3'd3,
        RA_LIMIT  = 3'd4,
        RA_START  = 3'd5,
        RA_QCTRL  = 3'd6,
        RA_SPARE  = 3'd7
    } reg_addr_e;

    localparam int CTRL_RUN_BIT    = 0;
    localparam int CTRL_UNLOCK_BIT = 1;
    localparam int GUARD_LOCK_BIT  = 0;
    localparam int DIVST_FLAG_BIT  = 7;
    localparam int QCTRL_EN_BIT    = 0;

    // Phase position in the forward rotation order 00,10,11,01
    function automatic logic [1:0] phase_index(input logic [1:0] ab);
        case (ab)
            2'b00:   phase_index = 2'd0;
            2'b10:   phase_index = 2'd1;
            2'b11:   phase_index = 2'd2;
            default: phase_index = 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/qdec_phase.sv
module qdec_phase #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_a,
    input  logic phase_b,
    output logic step_o,
    output logic up_o
);
    import qdec_pkg::*;

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0][1:0] sync;
        logic [1:0]                  prev;
    } ph_state_t;

    ph_state_t st_d, st_q;
    logic [1:0] cur_ab;
    logic [1:0] delta;

    always_comb begin
        st_d = st_q;
        st_d.sync[0] = {phase_a, phase_b};
        for (int i = 1; i < SYNC_STAGES; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        st_d.prev = st_q.sync[LAST];

        cur_ab = st_q.sync[LAST];
        delta  = phase_index(cur_ab) - phase_index(st_q.prev);
        step_o = (delta == 2'd1) || (delta == 2'd3);
        up_o   = (delta == 2'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SINGLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> ($countones(cur_ab ^ st_q.prev) == 1)); // R3

endmodule

// File: rtl/qdec_counter.sv
module qdec_counter #(
    parameter int CNT_W = 16,
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             up_i,
    input  logic             active_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] start_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic [DIV_W-1:0] div_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    localparam int PRE_W = (1 << DIV_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PRE_W-1:0] pre;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [PRE_W-1:0] thr;
    logic             apply;

    always_comb begin
        st_d   = st_q;
        apply  = 1'b0;
        wrap_o = 1'b0;
        thr    = (PRE_W'(1) << div_i) - PRE_W'(1);

        if (reload_i) begin
            st_d.cnt = start_i;
            st_d.pre = '0;
        end else if (active_i && step_i) begin
            if (st_q.pre >= thr) begin
                st_d.pre = '0;
                apply    = 1'b1;
            end else begin
                st_d.pre = st_q.pre + PRE_W'(1);
            end
        end

        if (apply) begin
            if (up_i) begin
                if (st_q.cnt == limit_i) begin
                    st_d.cnt = start_i;
                    wrap_o   = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end else begin
                if (st_q.cnt == start_i) begin
                    st_d.cnt = limit_i;
                    wrap_o   = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;

    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (count_o == $past(start_i))); // R6
    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && up_i && count_o != limit_i) |=> (count_o == $past(count_o) + CNT_W'(1))); // R2
    AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && up_i && count_o == limit_i) |=> (count_o == $past(start_i))); // R4
    AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !up_i && count_o == start_i) |=> (count_o == $past(limit_i))); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_i && !(active_i && step_i)) |=> $stable(count_o)); // R10

endmodule

// File: rtl/qdec_timer.sv
module qdec_timer #(
    parameter int CNT_W       = 16,
    parameter int ADDR_W      = 3,
    parameter int DIV_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_a,
    input  logic              phase_b,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [CNT_W-1:0]  pos_o
);
    import qdec_pkg::*;

    localparam logic [CNT_W-1:0] LIMIT_RST = '1;

    typedef struct packed {
        logic             run;
        logic             lock;
        logic             flag;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] limit;
        logic [CNT_W-1:0] start;
        logic             qen;
    } regs_t;

    regs_t rg_d, rg_q;

    logic step, up, wrap, reload, active;
    logic [CNT_W-1:0] count;
    logic wr_ctrl, wr_guard, wr_divst, wr_limit, wr_start, wr_qctrl;

    qdec_phase #(.SYNC_STAGES(SYNC_STAGES)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_a (phase_a),
        .phase_b (phase_b),
        .step_o  (step),
        .up_o    (up)
    );

    qdec_counter #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step),
        .up_i     (up),
        .active_i (active),
        .reload_i (reload),
        .start_i  (rg_q.start),
        .limit_i  (rg_q.limit),
        .div_i    (rg_q.div),
        .count_o  (count),
        .wrap_o   (wrap)
    );

    always_comb begin
        wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(RA_CTRL));
        wr_guard = bus_wr && (bus_addr == ADDR_W'(RA_GUARD));
        wr_divst = bus_wr && (bus_addr == ADDR_W'(RA_DIVST));
        reload   = bus_wr && (bus_addr == ADDR_W'(RA_POS));
        wr_limit = bus_wr && (bus_addr == ADDR_W'(RA_LIMIT));
        wr_start = bus_wr && (bus_addr == ADDR_W'(RA_START));
        wr_qctrl = bus_wr && (bus_addr == ADDR_W'(RA_QCTRL));
        active   = rg_q.run || rg_q.qen;

        rg_d = rg_q;
        if (wr_ctrl) begin
            if (!rg_q.lock)                 rg_d.run  = bus_wdata[CTRL_RUN_BIT];
            if (bus_wdata[CTRL_UNLOCK_BIT]) rg_d.lock = 1'b0;
        end
        if (wr_guard && bus_wdata[GUARD_LOCK_BIT]) rg_d.lock = 1'b1;
        if (wr_divst) begin
            if (bus_wdata[DIVST_FLAG_BIT]) rg_d.flag = 1'b0;
            if (!rg_q.lock)                rg_d.div  = bus_wdata[DIV_W-1:0];
        end
        if (wr_limit && !rg_q.lock)             rg_d.limit = bus_wdata;
        if (wr_start && !rg_q.lock && rg_q.run) rg_d.start = bus_wdata;
        if (wr_qctrl && !rg_q.lock && rg_q.run) rg_d.qen   = bus_wdata[QCTRL_EN_BIT];
        if (wrap) rg_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q       <= '0;
            rg_q.limit <= LIMIT_RST;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(RA_CTRL):  bus_rdata[CTRL_RUN_BIT]   = rg_q.run;
            ADDR_W'(RA_GUARD): bus_rdata[GUARD_LOCK_BIT] = rg_q.lock;
            ADDR_W'(RA_DIVST): begin
                bus_rdata[DIV_W-1:0]     = rg_q.div;
                bus_rdata[DIVST_FLAG_BIT] = rg_q.flag;
            end
            ADDR_W'(RA_POS):   bus_rdata = count;
            ADDR_W'(RA_LIMIT): bus_rdata = rg_q.limit;
            ADDR_W'(RA_START): bus_rdata = rg_q.start;
            ADDR_W'(RA_QCTRL): bus_rdata[QCTRL_EN_BIT]   = rg_q.qen;
            default:           bus_rdata = '0;
        endcase
    end

    assign pos_o = count;

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.lock && !(wr_ctrl && bus_wdata[CTRL_UNLOCK_BIT])) |=> rg_q.lock); // R9
    AST_LOCKED_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.lock && wr_limit) |=> $stable(rg_q.limit)); // R8
    AST_GATED_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!rg_q.run && wr_start) |=> $stable(rg_q.start)); // R7
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> rg_q.flag); // R4

endmodule

// File: tb/qdec_timer_test.sv
`timescale 1ns/1ps
module qdec_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pa = 1'b0, pb = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata, pos_o;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    int    ph = 0;
    string cur_req = "R1";

    qdec_timer uut (
        .clk(clk), .rst_n(rst_n), .phase_a(pa), .phase_b(pb),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pos_o(pos_o)
    );

    always #5 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    bit        m_run, m_lock, m_flag, m_qen;
    int        m_div, m_pre;
    int        m_cnt, m_start, m_limit;
    bit [1:0]  hist [4];

    function automatic int pos_of(bit [1:0] ab);
        case (ab)
            2'b00: return 0;
            2'b10: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_lock = 0; m_flag = 0; m_qen = 0;
            m_div = 0; m_pre = 0; m_cnt = 0; m_start = 0; m_limit = 16'hFFFF;
            for (int i = 0; i < 4; i++) hist[i] = 2'b00;
        end else begin
            bit o_run, o_lock, o_qen, wrapped, st_up, st_dn, apply;
            int o_div, o_start, o_limit, d;
            o_run = m_run; o_lock = m_lock; o_qen = m_qen;
            o_div = m_div; o_start = m_start; o_limit = m_limit;
            for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = {pa, pb};
            d = (pos_of(hist[2]) - pos_of(hist[3]) + 4) % 4;
            st_up = (d == 1); st_dn = (d == 3);
            wrapped = 0; apply = 0;
            if (bus_wr && bus_addr == 3) begin
                m_cnt = o_start; m_pre = 0;
            end else if ((o_run || o_qen) && (st_up || st_dn)) begin
                if (m_pre >= (1 << o_div) - 1) begin m_pre = 0; apply = 1; end
                else m_pre++;
            end
            if (apply) begin
                if (st_up) begin
                    if (m_cnt == o_limit) begin m_cnt = o_start; wrapped = 1; end
                    else m_cnt = (m_cnt + 1) & 16'hFFFF;
                end else begin
                    if (m_cnt == o_start) begin m_cnt = o_limit; wrapped = 1; end
                    else m_cnt = (m_cnt - 1) & 16'hFFFF;
                end
            end
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: begin
                        if (!o_lock) m_run = bus_wdata[0];
                        if (bus_wdata[1]) m_lock = 0;
                    end
                    3'd1: if (bus_wdata[0]) m_lock = 1;
                    3'd2: begin
                        if (bus_wdata[7]) m_flag = 0;
                        if (!o_lock) m_div = bus_wdata[2:0];
                    end
                    3'd4: if (!o_lock) m_limit = bus_wdata;
                    3'd5: if (!o_lock && o_run) m_start = bus_wdata;
                    3'd6: if (!o_lock && o_run) m_qen = bus_wdata[0];
                    default: ;
                endcase
            end
            if (wrapped) m_flag = 1;
        end
    end

    // cycle-by-cycle comparison of the position output
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (pos_o !== 16'(m_cnt)) begin
                errors++;
                $display("FAIL %s pos_o actual %h expected %h", cur_req, pos_o, 16'(m_cnt));
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d cycles expected completion", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- tasks ----------------
    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(bus_rdata, exp, req);
    endtask

    task automatic set_phase();
        case (ph % 4)
            0: begin pa = 0; pb = 0; end
            1: begin pa = 1; pb = 0; end
            2: begin pa = 1; pb = 1; end
            default: begin pa = 0; pb = 1; end
        endcase
    endtask

    task automatic turn(input int n);
        int k = (n < 0) ? -n : n;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            ph = (n < 0) ? (ph + 3) % 4 : (ph + 1) % 4;
            set_phase();
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic jump();
        @(negedge clk);
        ph = (ph + 2) % 4;
        set_phase();
        repeat (4) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";
        rd(3'd0, 16'h0000, "R1 ctrl");
        rd(3'd1, 16'h0000, "R1 guard");
        rd(3'd2, 16'h0000, "R1 divstat");
        rd(3'd3, 16'h0000, "R1 pos");
        rd(3'd4, 16'hFFFF, "R1 limit");
        rd(3'd5, 16'h0000, "R1 start");
        rd(3'd6, 16'h0000, "R1 qctrl");
        rd(3'd7, 16'h0000, "R11 spare");

        cur_req = "R10";
        turn(2);
        chk(pos_o, 16'd0, "R10 stopped when both enables clear");

        wr(3'd0, 16'h0001);
        wr(3'd6, 16'hFFFF);
        rd(3'd6, 16'h0001, "R11 qctrl unused bits zero");

        cur_req = "R2";
        turn(10);
        chk(pos_o, 16'd10, "R2 forward rotation");
        turn(-3);
        chk(pos_o, 16'd7, "R2 reverse rotation");

        cur_req = "R3";
        jump(); jump();
        chk(pos_o, 16'd7, "R3 double phase change");

        cur_req = "R6";
        wr(3'd4, 16'd12);
        wr(3'd5, 16'd5);
        wr(3'd3, 16'hABCD);
        chk(pos_o, 16'd5, "R6 reload ignores data");

        cur_req = "R4";
        turn(7);
        chk(pos_o, 16'd12, "R4 reach limit");
        turn(1);
        chk(pos_o, 16'd5, "R4 wrap up");
        rd(3'd2, 16'h0080, "R4 flag set");
        wr(3'd2, 16'h0080);
        rd(3'd2, 16'h0000, "R4 flag cleared");
        turn(-1);
        chk(pos_o, 16'd12, "R4 wrap down");
        rd(3'd2, 16'h0080, "R4 flag set on down wrap");

        cur_req = "R5";
        wr(3'd2, 16'h0082);
        rd(3'd2, 16'h0002, "R5 divider select");
        wr(3'd3, 16'h0000);
        turn(8);
        chk(pos_o, 16'd7, "R5 divide by four");

        cur_req = "R6";
        turn(3);
        chk(pos_o, 16'd7, "R6 partial divider count");
        wr(3'd3, 16'h0001);
        turn(1);
        chk(pos_o, 16'd5, "R6 reload clears divider");
        turn(3);
        chk(pos_o, 16'd6, "R6 divider restart");

        cur_req = "R7";
        wr(3'd0, 16'h0000);
        wr(3'd5, 16'd9);
        rd(3'd5, 16'd5, "R7 start write ignored");
        wr(3'd6, 16'h0000);
        rd(3'd6, 16'h0001, "R7 qctrl write ignored");
        turn(4);
        chk(pos_o, 16'd7, "R10 counting with quadrature enable only");

        cur_req = "R8";
        wr(3'd0, 16'h0001);
        wr(3'd1, 16'h0001);
        rd(3'd1, 16'h0001, "R8 lock set");
        wr(3'd4, 16'd3);
        rd(3'd4, 16'd12, "R8 limit locked");
        wr(3'd2, 16'h0000);
        rd(3'd2, 16'h0002, "R8 divider locked");
        wr(3'd5, 16'd8);
        rd(3'd5, 16'd5, "R8 start locked");
        wr(3'd6, 16'h0000);
        rd(3'd6, 16'h0001, "R8 qctrl locked");
        wr(3'd0, 16'h0000);
        rd(3'd0, 16'h0001, "R8 run bit locked");
        wr(3'd3, 16'h1234);
        chk(pos_o, 16'd5, "R8 reload allowed while locked");

        cur_req = "R9";
        wr(3'd1, 16'h0000);
        rd(3'd1, 16'h0001, "R9 zero write keeps lock");
        wr(3'd0, 16'h0003);
        rd(3'd1, 16'h0000, "R9 unlock");
        rd(3'd0, 16'h0001, "R9 unlock bit reads zero");
        wr(3'd4, 16'd20);
        rd(3'd4, 16'd20, "R9 limit writable again");

        cur_req = "R10";
        wr(3'd6, 16'h0000);
        wr(3'd0, 16'h0000);
        turn(8);
        chk(pos_o, 16'd5, "R10 counting stopped");
        rd(3'd3, 16'd5, "R10 pos readback");

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule